// File: doc/BRIEF.md
# Power-Up Strap Latch and Test-Mode Controller

This block captures the board strap inputs of a clock generator at the moment its active-low power-good line first goes low. From that point it holds the 3-bit CPU frequency code and the choice of function for the shared differential pair. It also presents the code as read-only status bits and decodes it into an ordered frequency index. The strap that normally carries frequency bit C also has a high-level indication, which the pin-sensing stage has already turned into a digital input. When that indication is seen at capture, the block enters test mode instead, and bit C is taken as 0.

Test mode can start from the strap or from a software entry bit. In both cases it is sticky, and only a power cycle (reset) ends it. The source decides what steers the outputs. After strap entry, a live mode pin chooses between tri-stating the outputs and driving the reference clock divided by N. After software entry, only a register mode bit makes that choice. A divide-by-N generator, running on the reference clock, provides the REF/N waveform.

Top module: `strap_test_ctl`

## Requirements
- R1: From reset until the capture edge, `latched`, `fsel_code`, `cpu_freq_idx`, `rb_fsel`, `shared_is_cpu`, `test_active`, `test_hiz`, `test_refn` and `refn_clk` are all 0.
- R2: At the first rising clock edge that sees `pwrgd_n` low, the straps are captured. `latched` goes to 1 and `fsel_code` becomes {C,B,A}, with C in bit 2 and A in bit 0.
- R3: After capture, changes on the strap inputs or on `pwrgd_n` do not alter any latched value until the next reset.
- R4: `cpu_freq_idx` orders the frequencies from lowest to highest: code 101 (100 MHz) gives 0, 001 (133.33) gives 1, 011 (166.66) gives 2, 010 (200) gives 3, 000 (266.66) gives 4, 100 (333.33) gives 5 and 110 (400) gives 6. The reserved code 111 gives 7.
- R5: `rb_fsel` bit 2 is latched C, bit 1 is latched B and bit 0 is latched A.
- R6: If `strap_c_test` is 1 at capture, test mode becomes active at that edge and latched bit C reads 0.
- R7: In strap-entered test mode, the live `mode_pin` steers the outputs within the same cycle: 0 sets `test_hiz`, and 1 sets `test_refn`. `sw_mode_sel` has no effect.
- R8: When test mode is not already active, `sw_test_entry` at 1 after capture enters test mode at the next edge. From then on `sw_mode_sel` alone steers the outputs (0 sets `test_hiz`, 1 sets `test_refn`), and `mode_pin` is ignored.
- R9: Once active, test mode stays active when the entry bit returns to 0. Only reset clears it.
- R10: `shared_is_cpu` equals the `strap_itp` value captured at power-good: 1 for the CPU debug clock, 0 for an SRC pair.
- R11: When `test_refn` is 1, `refn_clk` has a period of REF_DIV clocks and is high for REF_DIV/2 of them. When `test_refn` is 0, `refn_clk` is 0.
- R12: `sw_test_entry` held at 1 before capture does not activate test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-cycle reset, active low |
| pwrgd_n | input | 1 | Power-good, active low; its first low level triggers capture |
| strap_c | input | 1 | Frequency strap bit C (logic level) |
| strap_c_test | input | 1 | Decoded high-level indication on the C strap |
| strap_b | input | 1 | Frequency strap bit B |
| strap_a | input | 1 | Frequency strap bit A |
| strap_itp | input | 1 | Shared-pair function strap |
| mode_pin | input | 1 | Live test-mode pin |
| sw_test_entry | input | 1 | Register bit requesting test entry |
| sw_mode_sel | input | 1 | Register bit choosing the test mode after software entry |
| latched | output | 1 | Straps have been captured |
| fsel_code | output | 3 | Latched {C,B,A} |
| cpu_freq_idx | output | 3 | Frequency index decoded from the code |
| rb_fsel | output | 3 | Read-only status copy of {C,B,A} |
| shared_is_cpu | output | 1 | Shared pair runs as the CPU debug clock |
| test_active | output | 1 | Test mode is active |
| test_hiz | output | 1 | Outputs are tri-stated |
| test_refn | output | 1 | Outputs carry REF/N |
| refn_clk | output | 1 | Divided reference waveform |

## Verification
Strap-driven test entry and the software entry bit can both be present at the capture edge. The bench holds `sw_test_entry` and `sw_mode_sel` at 1 while the C strap shows its high level and `pwrgd_n` falls. It then toggles `mode_pin` and checks that the pin alone selects tri-state or REF/N. Capture and a pending software entry also meet at one edge: the bench requires test mode to stay off during the capture cycle itself, since software entry needs the straps to be latched first.

// File: rtl/strap_test_ctl.sv
module strap_test_ctl #(
  parameter int REF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_n,
  input  logic       strap_c,
  input  logic       strap_c_test,
  input  logic       strap_b,
  input  logic       strap_a,
  input  logic       strap_itp,
  input  logic       mode_pin,
  input  logic       sw_test_entry,
  input  logic       sw_mode_sel,
  output logic       latched,
  output logic [2:0] fsel_code,
  output logic [2:0] cpu_freq_idx,
  output logic [2:0] rb_fsel,
  output logic       shared_is_cpu,
  output logic       test_active,
  output logic       test_hiz,
  output logic       test_refn,
  output logic       refn_clk
);
  localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int HALF = REF_DIV / 2;

  logic hw_test, sw_test, mode_sel, refn_q;
  logic [CW-1:0] cnt, cnt_nxt;
  wire capture = !latched && !pwrgd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched       <= 1'b0;
      fsel_code     <= 3'b000;
      shared_is_cpu <= 1'b0;
      hw_test       <= 1'b0;
      sw_test       <= 1'b0;
    end else begin
      if (capture) begin
        latched       <= 1'b1;
        fsel_code     <= {strap_c & ~strap_c_test, strap_b, strap_a};
        shared_is_cpu <= strap_itp;
        hw_test       <= strap_c_test;
      end
      if (latched && !hw_test && sw_test_entry) sw_test <= 1'b1;
    end
  end

  always_comb begin
    case (fsel_code)
      3'b101:  cpu_freq_idx = 3'd0;
      3'b001:  cpu_freq_idx = 3'd1;
      3'b011:  cpu_freq_idx = 3'd2;
      3'b010:  cpu_freq_idx = 3'd3;
      3'b000:  cpu_freq_idx = latched ? 3'd4 : 3'd0;
      3'b100:  cpu_freq_idx = 3'd5;
      3'b110:  cpu_freq_idx = 3'd6;
      default: cpu_freq_idx = 3'd7;
    endcase
  end

  assign rb_fsel     = fsel_code;
  assign test_active = hw_test | sw_test;
  assign mode_sel    = hw_test ? mode_pin : sw_mode_sel;
  assign test_hiz    = test_active & ~mode_sel;
  assign test_refn   = test_active & mode_sel;

  assign cnt_nxt = (cnt == CW'(REF_DIV - 1)) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      refn_q <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      refn_q <= (cnt_nxt < CW'(HALF));
    end
  end

  assign refn_clk = test_refn & refn_q;

  assert_prelatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |-> (!test_active && fsel_code == 3'b000 && !shared_is_cpu));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched && !pwrgd_n) |=> latched);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> ($stable(fsel_code) && $stable(shared_is_cpu) && latched));

  assert_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({test_hiz, test_refn}) && (test_active == (test_hiz | test_refn)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |=> test_active);

  assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !test_refn |-> !refn_clk);

  assert_early_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |=> !$rose(test_active) || $past(!pwrgd_n));
endmodule

// File: tb/strap_test_ctl_test.sv
module strap_test_ctl_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, pwrgd_n = 1;
  logic strap_c = 0, strap_c_test = 0, strap_b = 0, strap_a = 0, strap_itp = 0;
  logic mode_pin = 0, sw_test_entry = 0, sw_mode_sel = 0;
  logic latched, shared_is_cpu, test_active, test_hiz, test_refn, refn_clk;
  logic [2:0] fsel_code, cpu_freq_idx, rb_fsel;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_sel[$]; int exp_val[$]; string exp_req[$];
  event chk_ev;

  always #5 clk = ~clk;

  strap_test_ctl #(.REF_DIV(N)) uut (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n),
    .strap_c(strap_c), .strap_c_test(strap_c_test), .strap_b(strap_b),
    .strap_a(strap_a), .strap_itp(strap_itp), .mode_pin(mode_pin),
    .sw_test_entry(sw_test_entry), .sw_mode_sel(sw_mode_sel),
    .latched(latched), .fsel_code(fsel_code), .cpu_freq_idx(cpu_freq_idx),
    .rb_fsel(rb_fsel), .shared_is_cpu(shared_is_cpu), .test_active(test_active),
    .test_hiz(test_hiz), .test_refn(test_refn), .refn_clk(refn_clk));

  function automatic int observe(int sel);
    case (sel)
      0: return int'(fsel_code);
      1: return int'(cpu_freq_idx);
      2: return int'(rb_fsel);
      3: return int'(shared_is_cpu);
      4: return int'(test_active);
      5: return int'(test_hiz);
      6: return int'(test_refn);
      7: return int'(refn_clk);
      default: return int'(latched);
    endcase
  endfunction

  function automatic int idx_of(int code);
    case (code)
      5: return 0; 1: return 1; 3: return 2; 2: return 3;
      0: return 4; 4: return 5; 6: return 6; default: return 7;
    endcase
  endfunction

  initial forever begin
    @(chk_ev);
    while (exp_sel.size() > 0) begin
      int s, v, a; string r;
      s = exp_sel.pop_front(); v = exp_val.pop_front(); r = exp_req.pop_front();
      a = observe(s);
      checks++;
      if (a !== v) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", r, s, a, v);
      end
    end
  end

  task automatic expect_v(int sel, int val, string req);
    exp_sel.push_back(sel); exp_val.push_back(val); exp_req.push_back(req);
  endtask

  task automatic judge();
    ->chk_ev; #1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic power_cycle();
    @(negedge clk); rst_n = 0; pwrgd_n = 1; sw_test_entry = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic capture(int c, int b, int a, int ctest, int itp);
    @(negedge clk);
    strap_c = c[0]; strap_b = b[0]; strap_a = a[0];
    strap_c_test = ctest[0]; strap_itp = itp[0]; pwrgd_n = 0;
    settle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    sw_test_entry = 1;
    repeat (3) @(negedge clk); #1;
    for (int s = 0; s <= 8; s++) expect_v(s, 0, "R1");
    expect_v(4, 0, "R12");
    judge();
    sw_test_entry = 0;

    capture(1, 0, 1, 0, 1);
    expect_v(8, 1, "R2"); expect_v(0, 5, "R2"); expect_v(1, 0, "R4");
    expect_v(2, 5, "R5"); expect_v(3, 1, "R10");
    judge();

    @(negedge clk);
    strap_c = 0; strap_b = 1; strap_a = 0; strap_itp = 0; strap_c_test = 1; pwrgd_n = 1;
    repeat (2) settle();
    pwrgd_n = 0; settle();
    expect_v(0, 5, "R3"); expect_v(3, 1, "R3"); expect_v(4, 0, "R3");
    judge();

    @(negedge clk); mode_pin = 1; sw_mode_sel = 0; sw_test_entry = 1;
    settle();
    expect_v(4, 1, "R8"); expect_v(5, 1, "R8"); expect_v(6, 0, "R8");
    judge();
    mode_pin = 0; #1;
    expect_v(5, 1, "R8"); judge();
    sw_mode_sel = 1; #1;
    expect_v(6, 1, "R8"); expect_v(5, 0, "R8"); judge();
    @(negedge clk); sw_test_entry = 0;
    repeat (3) settle();
    expect_v(4, 1, "R9"); judge();

    begin
      int highs;
      highs = 0;
      for (int i = 0; i < 2 * N; i++) begin
        settle();
        if (refn_clk === 1'b1) highs++;
      end
      checks++;
      if (highs != N) begin
        fails++;
        $display("FAIL R11 actual=%0d expected=%0d", highs, N);
      end
      highs = 0;
      for (int i = 0; i < N; i++) begin
        settle();
        if (refn_clk === 1'b1) highs++;
      end
      checks++;
      if (highs != N / 2) begin
        fails++;
        $display("FAIL R11 actual=%0d expected=%0d", highs, N / 2);
      end
    end
    sw_mode_sel = 0; #1;
    expect_v(7, 0, "R11"); judge();

    power_cycle(); #1;
    expect_v(4, 0, "R9"); expect_v(8, 0, "R9"); judge();

    for (int code = 0; code < 8; code++) begin
      power_cycle();
      capture((code >> 2) & 1, (code >> 1) & 1, code & 1, 0, code & 1);
      expect_v(0, code, "R2"); expect_v(1, idx_of(code), "R4");
      expect_v(3, code & 1, "R10");
      judge();
    end

    power_cycle();
    @(negedge clk); sw_test_entry = 1;
    capture(0, 1, 1, 0, 0);
    expect_v(4, 0, "R12"); judge();
    settle();
    expect_v(4, 1, "R8"); judge();

    power_cycle();
    @(negedge clk); sw_test_entry = 1; sw_mode_sel = 1; mode_pin = 0;
    capture(1, 1, 0, 1, 0);
    expect_v(4, 1, "R6"); expect_v(0, 2, "R6"); expect_v(2, 2, "R5");
    expect_v(3, 0, "R10"); expect_v(5, 1, "R7"); expect_v(6, 0, "R7");
    judge();
    mode_pin = 1; #1;
    expect_v(6, 1, "R7"); expect_v(5, 0, "R7"); judge();
    sw_mode_sel = 0; #1;
    expect_v(6, 1, "R7"); judge();
    mode_pin = 0; sw_test_entry = 0; #1;
    expect_v(5, 1, "R7"); judge();
    repeat (2) settle();
    expect_v(4, 1, "R9"); judge();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule